// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block sits between the status logic of a UART and the host bus. It watches the interrupt enable bits, the receive line status and the receive FIFO fill. It also watches a character-timeout flag, the transmit-holding-empty condition and the modem status change bits. From these it picks the single most urgent cause and presents it as an identification byte, together with one level interrupt line. The identification byte and the interrupt line are both registered. Both follow a change of any source on the next clock edge.

The block owns one piece of state: the transmit-empty pending flag. The flag is set when the holding register drains while that cause is enabled. It is resampled whenever software flips the enable bit for that cause. It is cleared by a write to the holding register, or by a read of the identification byte while that byte reports the transmit-empty cause.

Input meanings:
- Enable bit 0 enables receive data and also gates the timeout. Bit 1 enables transmit-empty, bit 2 enables line status and bit 3 enables modem status.
- Line status bit 0 is data ready. Bits 1 to 4 are overrun, parity, framing and break.

Top module: `uart_irq_id`

## Requirements
- R1: When several causes are active together, the reported cause is the highest-ranked one. The ranking from highest to lowest is: line status, character timeout, receive data, transmit empty, modem status.
- R2: The identification byte's bits 3:0 read 0x1 with no cause active. The active cause sets them as follows: line status 0x6, timeout 0xC, receive data 0x4, transmit empty 0x2, modem status 0x0.
- R3: The line status cause is active only when enable bit 2 is set and at least one of line status bits 1 to 4 is set. Bit 0 and bits 5 to 7 never raise it.
- R4: The character-timeout cause is enabled by enable bit 0, not by a separate bit. With enable bit 0 clear, neither code 0xC nor code 0x4 is ever reported.
- R5: The receive data cause requires enable bit 0 and data ready (line status bit 0). It also requires one of two FIFO conditions: the FIFO is disabled, or the FIFO count is at or above the trigger level.
- R6: A read strobe in a cycle where the identification byte shows 0x2 clears the transmit-empty pending flag. A read while another code is shown leaves the flag alone.
- R7: When enable bit 1 changes, the pending flag becomes 1 if bit 1 is now set and the holding register is empty. Otherwise the flag becomes 0.
- R8: A holding-register write strobe clears the transmit-empty pending flag.
- R9: Bits 7:6 of the identification byte read 11 while the FIFOs are enabled and 00 otherwise. Bits 5:4 read 0.
- R10: The interrupt line is a registered level equal to the inverse of identification bit 0. It changes on the first clock edge after a source changes.
- R11: After reset the identification byte reads 0x01, the interrupt line is low and the pending flag is clear.
- R12: A rise of the holding-empty input while enable bit 1 is set sets the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_i | input | 4 | Interrupt enable bits |
| lsr_i | input | 8 | Line status (bit 0 data ready, bits 1-4 errors) |
| fifo_en_i | input | 1 | FIFOs enabled |
| rx_cnt_i | input | CNT_W | Receive FIFO fill count |
| rx_trig_i | input | CNT_W | Receive trigger level |
| tmo_i | input | 1 | Character-timeout pending |
| thr_empty_i | input | 1 | Transmit holding register empty |
| msr_delta_i | input | 4 | Modem status change bits |
| iir_rd_i | input | 1 | Read strobe of the identification byte |
| thr_wr_i | input | 1 | Holding register write strobe |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench places several causes on the inputs at once to confirm that the lower ones are hidden. A wrong ranking would report, for example, 0xC while a break error is present.

Several corner cases get their own checks:
- Timeout with the receive-data enable clear. A design that used a separate enable for it would report 0xC here.
- A FIFO count one below the trigger level. A design with an off-by-one compare would report 0x4 early.
- Line status bits 5 to 7 on their own, which must not raise the line status cause.

The pending flag is exercised through the ports:
- Enable toggles with the holding register full and with it empty.
- A read while 0x6 hides a transmit-empty cause. A design that always cleared on read would then fall to 0x1 instead of 0x2.
- A write strobe, which must clear the flag.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam logic [3:0] ID_NONE = 4'h1;
  localparam logic [3:0] ID_LINE = 4'h6;
  localparam logic [3:0] ID_TMO  = 4'hC;
  localparam logic [3:0] ID_RXD  = 4'h4;
  localparam logic [3:0] ID_THR  = 4'h2;
  localparam logic [3:0] ID_MDM  = 4'h0;

  localparam int EN_RXD  = 0;
  localparam int EN_THR  = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;

  localparam int LS_DR     = 0;
  localparam int LS_ERR_LO = 1;
  localparam int LS_ERR_HI = 4;
endpackage

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
  input  logic clk,
  input  logic rst,
  input  logic thr_en_i,
  input  logic thr_empty_i,
  input  logic thr_wr_i,
  input  logic iir_rd_i,
  input  logic iir_is_thr_i,
  output logic pend_o
);
  logic en_q;
  logic empty_q;
  logic rd_clr;

  assign rd_clr = iir_rd_i && iir_is_thr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o  <= 1'b0;
      en_q    <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      en_q    <= thr_en_i;
      empty_q <= thr_empty_i;
      if (thr_wr_i || rd_clr)
        pend_o <= 1'b0;
      else if (thr_en_i != en_q)
        pend_o <= thr_en_i && thr_empty_i;
      else if (thr_en_i && thr_empty_i && !empty_q)
        pend_o <= 1'b1;
    end
  end

  // R8
  wr_clears_chk: assert property (@(posedge clk) disable iff (rst)
    thr_wr_i |=> !pend_o);
  // R6
  rd_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (iir_rd_i && iir_is_thr_i) |=> !pend_o);
  // R7
  en_resample_chk: assert property (@(posedge clk) disable iff (rst)
    (thr_en_i && !en_q && thr_empty_i && !thr_wr_i && !iir_rd_i) |=> pend_o);
  // R7
  dis_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (!thr_en_i && en_q) |=> !pend_o);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [3:0]       ier_i,
  input  logic [7:0]       lsr_i,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             tmo_i,
  input  logic             thr_pend_i,
  input  logic [3:0]       msr_delta_i,
  output logic [3:0]       code_o
);
  localparam int N_ERR = LS_ERR_HI - LS_ERR_LO + 1;

  logic [N_ERR-1:0] err_bits;
  logic             line_act, tmo_act, rxd_act, thr_act, mdm_act;

  for (genvar g = 0; g < N_ERR; g++) begin : g_err
    assign err_bits[g] = lsr_i[LS_ERR_LO + g];
  end

  assign line_act = ier_i[EN_LINE] && (|err_bits);
  assign tmo_act  = ier_i[EN_RXD] && tmo_i;
  assign rxd_act  = ier_i[EN_RXD] && lsr_i[LS_DR] &&
                    (!fifo_en_i || (rx_cnt_i >= rx_trig_i));
  assign thr_act  = ier_i[EN_THR] && thr_pend_i;
  assign mdm_act  = ier_i[EN_MDM] && (|msr_delta_i);

  always_comb begin
    if (line_act)     code_o = ID_LINE;
    else if (tmo_act) code_o = ID_TMO;
    else if (rxd_act) code_o = ID_RXD;
    else if (thr_act) code_o = ID_THR;
    else if (mdm_act) code_o = ID_MDM;
    else              code_o = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       ier_i,
  input  logic [7:0]       lsr_i,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             tmo_i,
  input  logic             thr_empty_i,
  input  logic [3:0]       msr_delta_i,
  input  logic             iir_rd_i,
  input  logic             thr_wr_i,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  logic       thr_pend;
  logic [3:0] code;

  uart_irq_thre u_thre (
    .clk         (clk),
    .rst         (rst),
    .thr_en_i    (ier_i[EN_THR]),
    .thr_empty_i (thr_empty_i),
    .thr_wr_i    (thr_wr_i),
    .iir_rd_i    (iir_rd_i),
    .iir_is_thr_i(iir_o[3:0] == ID_THR),
    .pend_o      (thr_pend)
  );

  uart_irq_prio #(.CNT_W(CNT_W)) u_prio (
    .ier_i      (ier_i),
    .lsr_i      (lsr_i),
    .fifo_en_i  (fifo_en_i),
    .rx_cnt_i   (rx_cnt_i),
    .rx_trig_i  (rx_trig_i),
    .tmo_i      (tmo_i),
    .thr_pend_i (thr_pend),
    .msr_delta_i(msr_delta_i),
    .code_o     (code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_o <= {4'h0, ID_NONE};
      irq_o <= 1'b0;
    end else begin
      iir_o <= {fifo_en_i, fifo_en_i, 2'b00, code};
      irq_o <= (code != ID_NONE);
    end
  end

  // R1
  line_top_chk: assert property (@(posedge clk) disable iff (rst)
    (ier_i[EN_LINE] && (|lsr_i[LS_ERR_HI:LS_ERR_LO])) |=> (iir_o[3:0] == ID_LINE));
  // R4
  tmo_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ier_i[EN_RXD] |=> (iir_o[3:0] != ID_TMO) && (iir_o[3:0] != ID_RXD));
  // R9
  fifo_bits_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (iir_o[7:6] == {2{$past(fifo_en_i)}}) && (iir_o[5:4] == 2'b00));
  // R10
  irq_agree_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o != iir_o[0]);
endmodule

// File: tb/uart_irq_id_tb.sv
module uart_irq_id_tb;
  localparam int CNT_W = 5;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] ier = 4'h0;
  logic [7:0] lsr = 8'h00;
  logic fen = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic [CNT_W-1:0] trig = '0;
  logic tmo = 1'b0;
  logic thr_empty = 1'b0;
  logic [3:0] msr = 4'h0;
  logic rd = 1'b0;
  logic wr = 1'b0;
  logic [7:0] iir;
  logic irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  uart_irq_id u_dut (
    .clk(clk), .rst(rst), .ier_i(ier), .lsr_i(lsr), .fifo_en_i(fen),
    .rx_cnt_i(cnt), .rx_trig_i(trig), .tmo_i(tmo), .thr_empty_i(thr_empty),
    .msr_delta_i(msr), .iir_rd_i(rd), .thr_wr_i(wr), .iir_o(iir), .irq_o(irq)
  );

  // {ier[35:32], lsr[31:24], fen[23], cnt[22:18], trig[17:13], tmo[12], msr[11:8], exp[7:0]}
  localparam logic [35:0] VEC [NV] = '{
    {4'h0, 8'h1F, 1'b0, 5'd0, 5'd0, 1'b1, 4'hF, 8'h01},
    {4'hD, 8'h03, 1'b1, 5'd0, 5'd1, 1'b1, 4'h1, 8'hC6},
    {4'hD, 8'h01, 1'b1, 5'd1, 5'd4, 1'b1, 4'h1, 8'hCC},
    {4'hC, 8'h01, 1'b1, 5'd8, 5'd4, 1'b1, 4'h1, 8'hC0},
    {4'h1, 8'h01, 1'b1, 5'd3, 5'd4, 1'b0, 4'h0, 8'hC1},
    {4'h1, 8'h01, 1'b1, 5'd4, 5'd4, 1'b0, 4'h0, 8'hC4},
    {4'h1, 8'h01, 1'b0, 5'd0, 5'd14, 1'b0, 4'h0, 8'h04},
    {4'h1, 8'h00, 1'b0, 5'd0, 5'd0, 1'b0, 4'h0, 8'h01},
    {4'h8, 8'h00, 1'b0, 5'd0, 5'd0, 1'b0, 4'h2, 8'h00},
    {4'h4, 8'h10, 1'b0, 5'd0, 5'd0, 1'b0, 4'h0, 8'h06},
    {4'h4, 8'hE1, 1'b0, 5'd0, 5'd0, 1'b0, 4'h0, 8'h01},
    {4'h5, 8'h09, 1'b1, 5'd0, 5'd1, 1'b1, 4'h0, 8'hC6},
    {4'h9, 8'h01, 1'b1, 5'd14, 5'd14, 1'b0, 4'h8, 8'hC4}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    // R11 reset state
    chk("R11 iir", iir, 8'h01);
    chk("R11 irq", {7'd0, irq}, 8'h00);

    // R1 R2 R3 R4 R5 R9 R10 table
    for (int v = 0; v < NV; v++) begin
      ier  = VEC[v][35:32];
      lsr  = VEC[v][31:24];
      fen  = VEC[v][23];
      cnt  = VEC[v][22:18];
      trig = VEC[v][17:13];
      tmo  = VEC[v][12];
      msr  = VEC[v][11:8];
      step(1);
      chk("R1/R2/R3/R4/R5/R9 iir", iir, VEC[v][7:0]);
      chk("R10 irq", {7'd0, irq}, {7'd0, ~VEC[v][0]});
    end

    // R10 timing: unchanged before the edge, updated after it
    ier = 4'h0; lsr = 8'h00; fen = 1'b0; tmo = 1'b0; msr = 4'h0;
    step(1);
    ier = 4'h8; msr = 4'h1;
    #1;
    chk("R10 before edge", {7'd0, irq}, 8'h00);
    step(1);
    chk("R10 after edge", {7'd0, irq}, 8'h01);
    ier = 4'h0; msr = 4'h0;
    step(1);

    // R7 enable with holding empty
    thr_empty = 1'b1;
    ier = 4'h2;
    step(2);
    chk("R7 set", iir, 8'h02);
    // R6 read while 0x2 clears
    rd = 1'b1;
    step(1);
    rd = 1'b0;
    step(1);
    chk("R6 read clears", iir, 8'h01);

    // R7 toggle with holding full gives 0
    thr_empty = 1'b0;
    ier = 4'h0;
    step(1);
    ier = 4'h2;
    step(2);
    chk("R7 full", iir, 8'h01);

    // R12 rise while enabled
    thr_empty = 1'b1;
    step(2);
    chk("R12 rise", iir, 8'h02);

    // R8 write clears
    wr = 1'b1;
    thr_empty = 1'b0;
    step(1);
    wr = 1'b0;
    step(1);
    chk("R8 write", iir, 8'h01);

    // R6 read while another code shown keeps the flag
    thr_empty = 1'b1;
    step(2);
    ier = 4'h6; lsr = 8'h04;
    step(1);
    chk("R1 line over thr", iir, 8'h06);
    rd = 1'b1;
    step(1);
    rd = 1'b0;
    lsr = 8'h00;
    step(1);
    chk("R6 read other keeps", iir, 8'h02);

    // R11 reset again
    rst = 1'b1;
    step(1);
    rst = 1'b0;
    ier = 4'h2;
    chk("R11 reset iir", iir, 8'h01);
    chk("R11 reset irq", {7'd0, irq}, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule